// File: doc/BRIEF.md
# Prescaled Down-Counting Private Timer

This block is a 32-bit down-counter that software programs through four word-wide registers in a 32-byte window. The registers hold a reload value, the live count, a control word and a sticky event flag. The control word holds four settings: an enable, a choice between one-shot and auto-reload operation, an interrupt enable and an 8-bit prescaler. The counter steps down once every prescaler+1 clock cycles. When the count runs out, the block raises its event flag. It then either stops, reloads the count from the reload register, or fires again, depending on the mode and on the zero-value rules below.

The interrupt line is a level: it is high while the event flag is set and interrupts are enabled. Zero values get exact handling. With a zero prescaler, a zero written to the reload value or to the count stops the timer without an event. With a nonzero prescaler, an auto-reload timer whose reload value is zero fires once every prescaled period.

Top module: `prv_timer`

## Requirements
- R1: After reset, the reload, count, control and status registers all read zero, the timer does not count, and `irq` is low.
- R2: Byte offsets are fixed: 0x0 is the reload value, 0x4 the count, 0x8 control and 0xC status. Any other offset reads zero. Control bits are: bit 0 enable, bit 1 auto-reload, bit 2 interrupt enable, bits [15:8] prescaler. All other control bits read zero.
- R3: While running, the count drops by one every prescaler+1 cycles, measured from the write that started it. A write to the reload value also loads the count and restarts the prescaler phase.
- R4: A step from 1 to 0 sets status bit 0. In one-shot mode the count then holds at zero and the timer stops, while the enable bit stays set.
- R5: `irq` is high exactly when status bit 0 and control bit 2 are both set.
- R6: Writing 1 to status bit 0 clears it and writing 0 there has no effect. An event in the same cycle wins over the clear.
- R7: In auto-reload mode with a nonzero reload value L, the count reaches zero and is reloaded with L on the next step. Events therefore repeat every L+1 steps.
- R8: An auto-reload timer with a zero reload value behaves in two ways. With a nonzero prescaler it raises the event on every step. With a zero prescaler it stops after its count reaches zero.
- R9: With a zero prescaler and enable set, two writes stop the timer without an event: writing zero to the reload value, and writing zero to the count in one-shot mode or when the reload value is zero.
- R10: With enable and auto-reload set and a zero prescaler, writing zero to the count loads the count from the reload value instead.
- R11: Clearing enable stops the count. A control write that sets enable and auto-reload with a zero prescaler while the count is zero first loads the count from the reload value. The timer only runs when enable is set.
- R12: A new prescaler value changes the step rate from the cycle after the control write, without waiting for the old phase to end.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Byte offset inside the window |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| irq | output | 1 | Level interrupt |

## Verification
On every cycle, the checker covers five rules: the one-step decrement, the one-shot stop after expiry, an event beating a same-cycle clear, the clear itself, and the silent stop on a zero reload write. It also checks that the counter never runs while disabled. The bench alone can show rules that span many cycles or depend on register values seen through the bus. These are the period lengths under different prescalers, the reload-at-zero sequence in auto-reload mode, the repeated firing with a zero reload value, the counter-write substitutions and the immediate effect of a prescaler change.

// File: rtl/prv_timer.sv
module prv_timer #(
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] A_LOAD = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_CNT  = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(8);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(12);
  localparam logic [CNT_W-1:0]  ONE    = CNT_W'(1);

  logic [CNT_W-1:0] load_q, cnt_q;
  logic             en_q, per_q, ie_q, status_q, run_q;
  logic [7:0]       pre_q, pcnt_q;

  logic wr_load, wr_cnt, wr_ctrl, wr_stat, tick, evt, pre_z, expire, keep_period;
  logic [CNT_W-1:0] wv, cnt_wr_val, ctl_cnt;
  logic [7:0]       wpre;

  assign wr_load = wr_en && (addr == A_LOAD);
  assign wr_cnt  = wr_en && (addr == A_CNT);
  assign wr_ctrl = wr_en && (addr == A_CTRL);
  assign wr_stat = wr_en && (addr == A_STAT);

  assign wv    = wdata[CNT_W-1:0];
  assign wpre  = wdata[15:8];
  assign pre_z = (pre_q == 8'd0);

  assign tick   = run_q && !(wr_load || wr_cnt || wr_ctrl) && (pcnt_q >= pre_q);
  assign expire = (cnt_q <= ONE);
  assign evt    = tick && ((cnt_q == ONE) ||
                           ((cnt_q == '0) && (!per_q || (load_q == '0))));
  assign keep_period = per_q && !(pre_z && (load_q == '0));

  assign cnt_wr_val = (en_q && per_q && pre_z && (wv == '0)) ? load_q : wv;
  assign ctl_cnt    = (wdata[0] && wdata[1] && (wpre == 8'd0) && (cnt_q == '0))
                      ? load_q : cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      load_q   <= '0;
      cnt_q    <= '0;
      en_q     <= 1'b0;
      per_q    <= 1'b0;
      ie_q     <= 1'b0;
      pre_q    <= 8'd0;
      pcnt_q   <= 8'd0;
      status_q <= 1'b0;
      run_q    <= 1'b0;
    end else begin
      pcnt_q <= (!run_q || wr_load || wr_cnt || tick) ? 8'd0 : pcnt_q + 8'd1;

      if (evt)
        status_q <= 1'b1;
      else if (wr_stat && wdata[0])
        status_q <= 1'b0;

      if (wr_load) begin
        load_q <= wv;
        cnt_q  <= wv;
        run_q  <= en_q && (!pre_z || (wv != '0));
      end else if (wr_cnt) begin
        cnt_q <= cnt_wr_val;
        run_q <= en_q && (!pre_z || (cnt_wr_val != '0));
      end else if (wr_ctrl) begin
        en_q  <= wdata[0];
        per_q <= wdata[1];
        ie_q  <= wdata[2];
        pre_q <= wpre;
        cnt_q <= ctl_cnt;
        run_q <= wdata[0] && ((wpre != 8'd0) || (ctl_cnt != '0));
      end else if (tick) begin
        if (cnt_q == '0)
          cnt_q <= per_q ? load_q : '0;
        else
          cnt_q <= cnt_q - ONE;
        if (expire)
          run_q <= keep_period;
      end
    end
  end

  always_comb begin
    case (addr)
      A_LOAD:  rdata = 32'(load_q);
      A_CNT:   rdata = 32'(cnt_q);
      A_CTRL:  rdata = {16'd0, pre_q, 5'd0, ie_q, per_q, en_q};
      A_STAT:  rdata = {31'd0, status_q};
      default: rdata = 32'd0;
    endcase
  end

  assign irq = status_q && ie_q;
endmodule

// File: rtl/prv_timer_chk.sv
module prv_timer_chk #(
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [31:0]       wdata,
  input logic              en_q,
  input logic              per_q,
  input logic [7:0]        pre_q,
  input logic              run_q,
  input logic [CNT_W-1:0]  cnt_q,
  input logic              status_q,
  input logic              tick,
  input logic              evt
);
  localparam logic [CNT_W-1:0]  ONE    = CNT_W'(1);
  localparam logic [ADDR_W-1:0] A_LOAD = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(12);

  // R3
  dec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && (cnt_q > ONE)) |=> (cnt_q == $past(cnt_q) - ONE));

  // R4
  oneshot_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && !per_q) |=> (!run_q && (cnt_q == '0)));

  // R6
  evt_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> status_q);

  // R6
  w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (addr == A_STAT) && wdata[0] && !evt) |=> !status_q);

  // R9
  silent_load_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (addr == A_LOAD) && (wdata == 32'd0) && en_q && (pre_q == 8'd0))
      |=> (!run_q && (status_q == $past(status_q))));

  // R11
  run_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> en_q);
endmodule

bind prv_timer prv_timer_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .en_q(en_q), .per_q(per_q), .pre_q(pre_q), .run_q(run_q), .cnt_q(cnt_q),
  .status_q(status_q), .tick(tick), .evt(evt)
);

// File: tb/prv_timer_tb.sv
module prv_timer_tb;
  localparam int CLK_P = 10;
  localparam logic [4:0] LD = 5'h00, CN = 5'h04, CT = 5'h08, ST = 5'h0C;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [4:0]  addr = 5'h0;
  logic [31:0] wdata = 32'h0;
  logic [31:0] rdata;
  logic        irq;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  prv_timer u_dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
                   .wdata(wdata), .rdata(rdata), .irq(irq));

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] v);
    addr = a;
    #1;
    v = rdata;
  endtask

  task automatic wait_e(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic expect_reg(input string req, input logic [4:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(req, v, exp);
  endtask

  function automatic logic [31:0] exp_cnt(input int l, input int p, input int n);
    int s = n / (p + 1);
    return (s >= l) ? 32'd0 : 32'(l - s);
  endfunction

  function automatic logic exp_evt(input int l, input int p, input int n);
    return n >= l * (p + 1);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: got hang expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    process::self().srandom(32'd4242);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    wait_e(2);

    expect_reg("R1 load", LD, 0);
    expect_reg("R1 count", CN, 0);
    expect_reg("R1 ctrl", CT, 0);
    expect_reg("R1 status", ST, 0);
    chk("R1 irq", {31'd0, irq}, 0);
    expect_reg("R2 unmapped 0x10", 5'h10, 0);
    expect_reg("R2 unmapped 0x1C", 5'h1C, 0);

    wr(CT, 32'hFFFF_FFF8);
    expect_reg("R2 ctrl field mask", CT, 32'h0000_FF00);
    wr(CT, 0);

    // R4 one-shot expiry
    wr(CT, 32'h1);
    wr(LD, 5);
    wait_e(4);
    expect_reg("R3 count before expiry", CN, 1);
    expect_reg("R4 no early event", ST, 0);
    wait_e(1);
    expect_reg("R4 count zero", CN, 0);
    expect_reg("R4 event set", ST, 1);
    chk("R5 irq masked", {31'd0, irq}, 0);
    wait_e(5);
    expect_reg("R4 holds zero", CN, 0);
    expect_reg("R4 enable kept", CT, 1);

    // R5 / R6
    wr(CT, 32'h5);
    chk("R5 irq on enable", {31'd0, irq}, 1);
    wr(ST, 0);
    expect_reg("R6 zero write ignored", ST, 1);
    wr(ST, 1);
    expect_reg("R6 cleared", ST, 0);
    chk("R5 irq low", {31'd0, irq}, 0);

    // R3 prescaler, R12 change
    wr(CT, 0);
    wr(LD, 4);
    wr(CT, 32'h301);
    wait_e(7);
    expect_reg("R3 presc 7 cyc", CN, 3);
    wait_e(1);
    expect_reg("R3 presc 8 cyc", CN, 2);
    wr(CT, 32'h101);
    wait_e(1);
    expect_reg("R12 new rate", CN, 1);
    wr(CT, 0);
    wr(ST, 1);

    // R7 periodic reload
    wr(LD, 3);
    wr(CT, 32'h3);
    wait_e(2);
    expect_reg("R7 count 1", CN, 1);
    wait_e(1);
    expect_reg("R7 zero", CN, 0);
    expect_reg("R7 event", ST, 1);
    wait_e(1);
    expect_reg("R7 reloaded", CN, 3);
    wr(ST, 1);
    expect_reg("R7 cleared", ST, 0);
    wait_e(2);
    expect_reg("R7 second event", ST, 1);
    wr(CT, 0);
    wr(ST, 1);

    // R8 zero reload, nonzero prescaler
    wr(LD, 0);
    wr(CT, 32'h203);
    wait_e(2);
    expect_reg("R8 before", ST, 0);
    wait_e(1);
    expect_reg("R8 first", ST, 1);
    wr(ST, 1);
    wait_e(1);
    expect_reg("R8 cleared", ST, 0);
    wait_e(1);
    expect_reg("R8 refire", ST, 1);
    wr(CT, 0);
    wr(ST, 1);

    // R8 zero reload, zero prescaler stops
    wr(LD, 0);
    wr(CN, 2);
    wr(CT, 32'h3);
    wait_e(2);
    expect_reg("R8 expire", ST, 1);
    wr(ST, 1);
    wait_e(6);
    expect_reg("R8 stopped no refire", ST, 0);
    expect_reg("R8 count zero", CN, 0);
    wr(CT, 0);

    // R9 silent stops
    wr(LD, 10);
    wr(CT, 32'h1);
    wait_e(3);
    expect_reg("R9 running", CN, 7);
    wr(LD, 0);
    wait_e(20);
    expect_reg("R9 load zero", LD, 0);
    expect_reg("R9 count zero", CN, 0);
    expect_reg("R9 no event load", ST, 0);
    wr(LD, 10);
    wait_e(2);
    wr(CN, 0);
    wait_e(15);
    expect_reg("R9 count stays", CN, 0);
    expect_reg("R9 no event count", ST, 0);

    // R10 counter zero substitution
    wr(CT, 0);
    wr(LD, 6);
    wr(CT, 32'h3);
    wait_e(2);
    expect_reg("R10 running", CN, 4);
    wr(CN, 0);
    expect_reg("R10 reload value", CN, 6);
    wait_e(1);
    expect_reg("R10 continues", CN, 5);

    // R11 disable stops, enable-at-zero reload
    wait_e(2);
    wr(CT, 0);
    wait_e(10);
    expect_reg("R11 frozen", CN, 3);
    wr(LD, 9);
    wr(CN, 0);
    wr(CT, 32'h3);
    expect_reg("R11 reload on enable", CN, 9);
    wait_e(1);
    expect_reg("R11 runs", CN, 8);
    wr(CT, 0);
    wr(ST, 1);

    // R6 event beats clear
    wr(LD, 4);
    wr(CT, 32'h1);
    wait_e(3);
    wr(ST, 1);
    expect_reg("R6 event wins", ST, 1);
    expect_reg("R4 count at expiry", CN, 0);

    // random one-shot runs
    for (int i = 0; i < 16; i++) begin
      int l = 1 + int'($urandom_range(29));
      int p = int'($urandom_range(3));
      int ie = int'($urandom_range(1));
      int n = int'($urandom_range(l * (p + 1) + 5));
      logic ev;
      wr(CT, 0);
      wr(ST, 1);
      wr(LD, 32'(l));
      wr(CT, 32'(p << 8) | 32'(ie << 2) | 32'h1);
      wait_e(n);
      ev = exp_evt(l, p, n);
      expect_reg("R3 random count", CN, exp_cnt(l, p, n));
      expect_reg("R4 random event", ST, {31'd0, ev});
      chk("R5 random irq", {31'd0, irq}, {31'd0, ev && (ie == 1)});
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule